// File: doc/BRIEF.md
# Console System Bus Address Decoder

This block sits between a console CPU and its on-board memories. It takes a 24-bit address, made of an 8-bit bank and a 16-bit offset, and works out which device should answer. The decision is made on 256-byte pages. The possible targets are the 128 KB work RAM, the memory-mapped I/O window, or nothing at all. For a RAM or I/O hit it produces the offset inside that device. It also returns the read data for the cycle.

The work RAM is reached in two ways:
- Its first 8 KB is mirrored into the low pages of two shadowed bank ranges.
- Two dedicated banks expose the whole 128 KB linearly.

The I/O window is repeated in every shadowed bank. Inside the window, a device claims its address with a presence flag.

The block keeps a byte register that holds the last value carried on the data bus. Any read that no device answers returns this byte instead. Writes to such addresses go nowhere, but the byte they carried is still captured. A debug read is free of side effects: inside the I/O window it returns zero, never selects the device and leaves the held byte alone.

Top module: `sbus_addr_decoder`

## Requirements
- R1: In banks 0x00–0x3F and 0x80–0xBF, offsets 0x0000–0x1FFF assert `ram_sel_o` during a read or write. In that case `loc_off_o` equals the offset modulo 0x2000, zero-extended to 17 bits.
- R2: In banks 0x7E and 0x7F, every offset asserts `ram_sel_o` during a read or write. In that case `loc_off_o = {bank[0], offset}`, which places bank 0x7E in the lower 64 KB and 0x7F in the upper 64 KB.
- R3: In the shadowed banks, offsets 0x2000–0x5FFF form the I/O window. A non-debug read or write there with `mmio_claim_i` high asserts `mmio_sel_o` and sets `loc_off_o` to the 16-bit offset. On a read, `rdata_o` equals `mmio_rdata_i`.
- R4: Every other address asserts no select and drives `loc_off_o` to zero. Examples are banks 0x40–0x7D and 0xC0–0xFF, and offsets 0x6000 and above in the shadowed banks.
- R5: A read that selects no device returns `hold_o` on `rdata_o`. This covers unmapped space and the I/O window with `mmio_claim_i` low. A read that selects RAM returns `ram_rdata_i`.
- R6: A write to unmapped space, or to an unclaimed I/O address, asserts no select.
- R7: On the clock edge that ends a write, `hold_o` takes `wdata_i`. On the edge that ends a non-debug read, `hold_o` takes the value `rdata_o` showed.
- R8: A debug read (`dbg_i` high with `rd_i`) in the I/O window returns 0x00 and keeps `mmio_sel_o` low. No debug read changes `hold_o`.
- R9: With `rd_i` and `wr_i` both low, both selects stay low and `hold_o` keeps its value.
- R10: While reset is asserted, and after it is released, `hold_o` is 0x00 until the first completed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | CPU address: bank in bits 23:16, offset in 15:0 |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| dbg_i | input | 1 | Side-effect-free debug access qualifier |
| wdata_i | input | 8 | Write data |
| ram_rdata_i | input | 8 | Data returned by work RAM |
| mmio_rdata_i | input | 8 | Data returned by the I/O device |
| mmio_claim_i | input | 1 | A device exists at the current I/O address |
| ram_sel_o | output | 1 | Work RAM select |
| mmio_sel_o | output | 1 | I/O device select |
| loc_off_o | output | 17 | Device-local offset |
| rdata_o | output | 8 | Read data to the CPU |
| hold_o | output | 8 | Last value carried on the data bus |

## Verification
The bench probes the edges of each region.
- Offset 0x1FFF against 0x2000 and 0x5FFF against 0x6000: an off-by-one page compare would move either RAM or I/O by one page.
- Banks 0x3F, 0x40, 0xBF and 0xC0: a shadow-range decode that is too wide or too narrow would select a device in a bank that has none.
- Banks 0x7E and 0x7F: a wrong bank-to-address join would fold both onto the same 64 KB.

The held byte is checked in sequence across several accesses:
- after a RAM read and after a write;
- across a debug read and an idle cycle, where a careless capture enable would overwrite it;
- through an unclaimed I/O read, which must echo the held byte rather than the device data.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 8;
  localparam int RAM_AW  = 17;
  localparam int LOC_W   = (RAM_AW > 16) ? RAM_AW : 16;

  typedef enum logic [1:0] {
    RGN_NONE    = 2'd0,
    RGN_LOWRAM  = 2'd1,
    RGN_FULLRAM = 2'd2,
    RGN_MMIO    = 2'd3
  } rgn_e;
endpackage

// File: rtl/sbus_region_decode.sv
module sbus_region_decode
  import sbus_pkg::*;
#(
  parameter int NUM_SHADOW     = 2,
  parameter int SHADOW_STRIDE  = 'h80,
  parameter int SHADOW_SPAN    = 'h40,
  parameter int LOWRAM_BYTES   = 'h2000,
  parameter int FULL_BANK_BASE = 'h7E,
  parameter int FULL_BANKS     = 2,
  parameter int MMIO_LO        = 'h2000,
  parameter int MMIO_HI        = 'h5FFF
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              region,
  output logic [LOC_W-1:0]  loc_off
);
  localparam int LOW_AW       = $clog2(LOWRAM_BYTES);
  localparam int LOW_PAGES    = LOWRAM_BYTES >> 8;
  localparam int MMIO_LO_PAGE = MMIO_LO >> 8;
  localparam int MMIO_HI_PAGE = MMIO_HI >> 8;

  logic [7:0]  bank;
  logic [7:0]  page;
  logic [15:0] off;
  logic [NUM_SHADOW-1:0] shadow_hit;
  logic in_shadow, low_hit, full_hit, mmio_hit;
  logic [7:0]  bank_rel;
  logic [23:0] full_lin;

  assign bank = addr[23:16];
  assign off  = addr[15:0];
  assign page = addr[15:8];

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_shadow
    assign shadow_hit[i] = (int'(bank) >= i*SHADOW_STRIDE) &&
                           (int'(bank) <  i*SHADOW_STRIDE + SHADOW_SPAN);
  end

  assign in_shadow = |shadow_hit;
  assign low_hit   = in_shadow && (int'(page) < LOW_PAGES);
  assign full_hit  = (int'(bank) >= FULL_BANK_BASE) &&
                     (int'(bank) <  FULL_BANK_BASE + FULL_BANKS);
  assign mmio_hit  = in_shadow && (int'(page) >= MMIO_LO_PAGE) &&
                     (int'(page) <= MMIO_HI_PAGE);
  assign bank_rel  = bank - 8'(FULL_BANK_BASE);
  assign full_lin  = {bank_rel, off};

  always_comb begin
    region  = RGN_NONE;
    loc_off = '0;
    if (low_hit) begin
      region  = RGN_LOWRAM;
      loc_off = LOC_W'(off[LOW_AW-1:0]);
    end else if (full_hit) begin
      region  = RGN_FULLRAM;
      loc_off = LOC_W'(full_lin[RAM_AW-1:0]);
    end else if (mmio_hit) begin
      region  = RGN_MMIO;
      loc_off = LOC_W'(off);
    end
  end
endmodule

// File: rtl/sbus_rdata_mux.sv
module sbus_rdata_mux
  import sbus_pkg::*;
(
  input  rgn_e              region,
  input  logic              dbg,
  input  logic              claim,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] mmio_rdata,
  input  logic [DATA_W-1:0] hold,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    unique case (region)
      RGN_LOWRAM, RGN_FULLRAM: rdata = ram_rdata;
      RGN_MMIO: begin
        if (dbg)        rdata = '0;
        else if (claim) rdata = mmio_rdata;
        else            rdata = hold;
      end
      default: rdata = hold;
    endcase
  end
endmodule

// File: rtl/sbus_openbus_reg.sv
module sbus_openbus_reg
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] hold
);
  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (cap_en) hold_d = cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(hold_q));
  a_r7_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> hold_q == $past(cap_data));
endmodule

// File: rtl/sbus_addr_decoder.sv
module sbus_addr_decoder
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic [23:0]       addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              dbg_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        ram_rdata_i,
  input  logic [7:0]        mmio_rdata_i,
  input  logic              mmio_claim_i,
  output logic              ram_sel_o,
  output logic              mmio_sel_o,
  output logic [16:0]       loc_off_o,
  output logic [7:0]        rdata_o,
  output logic [7:0]        hold_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  rgn_e              region;
  logic [LOC_W-1:0]  loc_off;
  logic              access, is_ram, is_mmio, cap_en;
  logic [DATA_W-1:0] cap_data;

  sbus_region_decode u_decode (
    .addr    (addr_i),
    .region  (region),
    .loc_off (loc_off)
  );

  sbus_rdata_mux u_mux (
    .region     (region),
    .dbg        (dbg_i),
    .claim      (mmio_claim_i),
    .ram_rdata  (ram_rdata_i),
    .mmio_rdata (mmio_rdata_i),
    .hold       (hold_o),
    .rdata      (rdata_o)
  );

  assign access     = rd_i | wr_i;
  assign is_ram     = (region == RGN_LOWRAM) || (region == RGN_FULLRAM);
  assign is_mmio    = (region == RGN_MMIO);
  assign ram_sel_o  = access && is_ram;
  assign mmio_sel_o = access && is_mmio && mmio_claim_i && !dbg_i;
  assign loc_off_o  = loc_off[16:0];
  assign cap_en     = wr_i || (rd_i && !dbg_i);
  assign cap_data   = wr_i ? wdata_i : rdata_o;

  sbus_openbus_reg u_openbus (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_data (cap_data),
    .hold     (hold_o)
  );

  a_r3_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel_o, mmio_sel_o}));
  a_r9_no_select_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i && !wr_i |-> !ram_sel_o && !mmio_sel_o);
  a_r5_unmapped_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !wr_i && !dbg_i && !ram_sel_o && !mmio_sel_o |-> rdata_o == hold_o);
  a_r8_debug_no_device: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_i |-> !mmio_sel_o);
  a_r8_debug_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && dbg_i && !wr_i |=> $stable(hold_o));
endmodule

// File: tb/sbus_addr_decoder_tb_top.sv
module sbus_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [23:0] addr_i;
  logic        rd_i, wr_i, dbg_i, mmio_claim_i;
  logic [7:0]  wdata_i, ram_rdata_i, mmio_rdata_i;
  logic        ram_sel_o, mmio_sel_o;
  logic [16:0] loc_off_o;
  logic [7:0]  rdata_o, hold_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_hold;

  always #4 clk = ~clk;

  sbus_addr_decoder dut_i (
    .clk(clk), .arst_n(arst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .dbg_i(dbg_i), .wdata_i(wdata_i), .ram_rdata_i(ram_rdata_i),
    .mmio_rdata_i(mmio_rdata_i), .mmio_claim_i(mmio_claim_i),
    .ram_sel_o(ram_sel_o), .mmio_sel_o(mmio_sel_o), .loc_off_o(loc_off_o),
    .rdata_o(rdata_o), .hold_o(hold_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [23:0] a, input logic r, input logic w,
                       input logic d, input logic [7:0] wd, input logic cl);
    @(negedge clk);
    addr_i = a; rd_i = r; wr_i = w; dbg_i = d; wdata_i = wd; mmio_claim_i = cl;
    #1;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    #1;
    rd_i = 1'b0; wr_i = 1'b0; dbg_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 hold in reset", hold_o, 8'h00);
    @(negedge clk); arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 hold after release", hold_o, 8'h00);
    exp_hold = 8'h00;
  endtask

  task automatic low_case(input logic [23:0] a, input logic [7:0] rdv);
    ram_rdata_i = rdv;
    drive(a, 1, 0, 0, 8'h00, 0);
    chk("R1 ram_sel", ram_sel_o, 1);
    chk("R1 mmio_sel", mmio_sel_o, 0);
    chk("R1 loc_off", loc_off_o, {4'd0, a[12:0]});
    chk("R5 ram rdata", rdata_o, rdv);
    finish_cycle();
    exp_hold = rdv;
    chk("R7 hold after read", hold_o, exp_hold);
  endtask

  task automatic t_low_mirror();
    low_case(24'h00_0123, 8'hA5);
    low_case(24'h3F_1FFF, 8'h5A);
    low_case(24'h80_0005, 8'h11);
    low_case(24'hBF_1FFF, 8'h22);
  endtask

  task automatic full_case(input logic [23:0] a, input logic [7:0] rdv);
    ram_rdata_i = rdv;
    drive(a, 1, 0, 0, 8'h00, 0);
    chk("R2 ram_sel", ram_sel_o, 1);
    chk("R2 loc_off", loc_off_o, {a[16], a[15:0]});
    chk("R2 rdata", rdata_o, rdv);
    finish_cycle();
    exp_hold = rdv;
  endtask

  task automatic t_full_bank();
    full_case(24'h7E_1234, 8'h33);
    full_case(24'h7F_FFFF, 8'h44);
    full_case(24'h7F_0000, 8'h45);
  endtask

  task automatic mmio_case(input logic [23:0] a, input logic [7:0] rdv);
    mmio_rdata_i = rdv;
    drive(a, 1, 0, 0, 8'h00, 1);
    chk("R3 mmio_sel", mmio_sel_o, 1);
    chk("R3 ram_sel", ram_sel_o, 0);
    chk("R3 loc_off", loc_off_o, {1'b0, a[15:0]});
    chk("R3 rdata", rdata_o, rdv);
    finish_cycle();
    exp_hold = rdv;
    chk("R7 hold after mmio read", hold_o, exp_hold);
  endtask

  task automatic t_mmio();
    mmio_case(24'h00_2100, 8'h3C);
    mmio_case(24'hBF_5FFF, 8'hC3);
    mmio_case(24'h80_2000, 8'h6D);
  endtask

  task automatic unmapped_read(input logic [23:0] a, input logic cl);
    ram_rdata_i = 8'hEE; mmio_rdata_i = 8'hDD;
    drive(a, 1, 0, 0, 8'h00, cl);
    chk("R4 ram_sel", ram_sel_o, 0);
    chk("R4 mmio_sel", mmio_sel_o, 0);
    chk("R4 loc_off", loc_off_o, 17'd0);
    chk("R5 open bus", rdata_o, exp_hold);
    finish_cycle();
    chk("R7 hold keeps echoed value", hold_o, exp_hold);
  endtask

  task automatic t_unmapped_read();
    unmapped_read(24'h40_0000, 1);
    unmapped_read(24'h7D_2100, 1);
    unmapped_read(24'hC0_0000, 1);
    unmapped_read(24'h00_6000, 1);
    unmapped_read(24'h3F_8000, 1);
    mmio_rdata_i = 8'hDD;
    drive(24'h00_2200, 1, 0, 0, 8'h00, 0);
    chk("R5 unclaimed mmio sel", mmio_sel_o, 0);
    chk("R5 unclaimed mmio rdata", rdata_o, exp_hold);
    finish_cycle();
  endtask

  task automatic t_unmapped_write();
    drive(24'hC0_1000, 0, 1, 0, 8'h9B, 1);
    chk("R6 ram_sel", ram_sel_o, 0);
    chk("R6 mmio_sel", mmio_sel_o, 0);
    finish_cycle();
    exp_hold = 8'h9B;
    chk("R7 hold after write", hold_o, exp_hold);
    drive(24'h00_3000, 0, 1, 0, 8'h4E, 0);
    chk("R6 unclaimed mmio write", mmio_sel_o, 0);
    finish_cycle();
    exp_hold = 8'h4E;
    chk("R7 hold after mmio write", hold_o, exp_hold);
    drive(24'h7E_0010, 0, 1, 0, 8'h71, 0);
    chk("R2 write ram_sel", ram_sel_o, 1);
    finish_cycle();
    exp_hold = 8'h71;
    chk("R7 hold after ram write", hold_o, exp_hold);
  endtask

  task automatic t_debug();
    mmio_rdata_i = 8'h77;
    drive(24'h00_2180, 1, 0, 1, 8'h00, 1);
    chk("R8 debug rdata", rdata_o, 8'h00);
    chk("R8 debug mmio_sel", mmio_sel_o, 0);
    finish_cycle();
    chk("R8 debug hold", hold_o, exp_hold);
    ram_rdata_i = 8'h19;
    drive(24'h7E_0400, 1, 0, 1, 8'h00, 0);
    chk("R8 debug ram rdata", rdata_o, 8'h19);
    finish_cycle();
    chk("R8 debug ram hold", hold_o, exp_hold);
  endtask

  task automatic t_idle();
    ram_rdata_i = 8'hF0; mmio_rdata_i = 8'h0F;
    drive(24'h00_0100, 0, 0, 0, 8'hAB, 1);
    chk("R9 idle ram_sel", ram_sel_o, 0);
    drive(24'h00_2100, 0, 0, 0, 8'hAB, 1);
    chk("R9 idle mmio_sel", mmio_sel_o, 0);
    finish_cycle();
    chk("R9 idle hold", hold_o, exp_hold);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; addr_i = '0; rd_i = 0; wr_i = 0; dbg_i = 0;
    wdata_i = '0; ram_rdata_i = '0; mmio_rdata_i = '0; mmio_claim_i = 0;
    exp_hold = '0;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_low_mirror();
    t_full_bank();
    t_mmio();
    t_unmapped_read();
    t_unmapped_write();
    t_debug();
    t_idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule